// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a handful of recently used page translations and turns a 32-bit virtual address into a physical address in one lookup cycle. Pages are 4 KB, so the low 12 bits of the address bypass translation. Only the 20-bit page number is mapped to a 20-bit frame number. Each stored translation is tagged with an 8-bit address-space number. It also carries three permission flags: readable, writable and user-accessible.

A requester offers a lookup on a valid/ready channel. One cycle after acceptance the block returns exactly one outcome: a hit with the physical address, a miss, or a permission fault. After a miss, the requester fetches the translation itself. It delivers the translation on a second valid/ready channel, which writes it into the lowest free slot. When no slot is free, a free-running 4-bit LFSR picks the victim.

Two flush pins clear the stored translations. One clears all of them. The other clears only those belonging to a chosen address space.

Back-pressure rules:
- A flush has priority over everything else, so `fill_ready` is low during any flush cycle.
- A lookup has the lowest priority, so `req_ready` is low whenever a flush or a fill is presented.
- The response channel carries no back-pressure: the requester must take each outcome in the cycle it appears.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot holds a translation. `rsp_valid` is low, both ready outputs are high, and the first lookup reports a miss.
- R2: A lookup matches when a valid slot has the same page number (address bits 31:12) and the same address-space number, and the access is permitted. It then reports a hit with `rsp_paddr` = {frame number, address bits 11:0}.
- R3: A slot stored under one address-space number never matches a lookup made under a different address-space number.
- R4: The access is checked against the matching slot's flags. A write needs writable, a read needs readable, and a user access (`req_user`=1) also needs user-accessible. A denied access reports a fault with `rsp_paddr` = 0.
- R5: A lookup with no matching valid slot reports a miss with `rsp_paddr` = 0.
- R6: `rsp_valid` is high exactly in the cycle after an accepted lookup. With it, exactly one of hit, miss and fault is high. All three are low otherwise.
- R7: An accepted fill writes the lowest-index invalid slot at the clock edge. A lookup accepted in the following cycle sees it.
- R8: A fill into a full table replaces exactly one slot. The victim index is the current nonzero 4-bit LFSR state, so slot 0 is never the victim.
- R9: `flush_all` invalidates every slot at the next clock edge.
- R10: `flush_asid_en` invalidates only the slots whose address-space number equals `flush_asid`. Other slots still hit.
- R11: If several valid slots match one lookup, the lowest-index slot supplies the frame number and flags.
- R12: Flush outranks fill, and fill outranks lookup. `req_ready` is low while a flush or `fill_valid` is present, and `fill_ready` is low during a flush. A fill offered during a flush is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup offered |
| req_ready | output | 1 | Lookup can be taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space number of the lookup |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Outcome present |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No matching translation |
| rsp_fault | output | 1 | Translation found, access denied |
| rsp_paddr | output | 32 | Physical address on hit, else 0 |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_vpn | input | 20 | Page number to store |
| fill_asid | input | 8 | Address-space number to store |
| fill_pfn | input | 20 | Frame number to store |
| fill_rd | input | 1 | Readable flag |
| fill_wr | input | 1 | Writable flag |
| fill_usr | input | 1 | User-accessible flag |
| flush_all | input | 1 | Invalidate all slots |
| flush_asid_en | input | 1 | Invalidate slots of one address space |
| flush_asid | input | 8 | Address space to invalidate |

## Verification
A lookup outcome is registered: the bench drives a request half a cycle before an edge and samples the outcome at the falling edge after that edge. It then confirms at the next falling edge that `rsp_valid` has dropped. Fills and flushes act at the edge they are accepted on, so the bench issues the lookup that observes them in the following cycle. Ready outputs are combinational, so the bench checks them a short delay after changing the offering inputs within the same low phase. Expected outcomes come from a slot-by-slot model kept by the bench. The only exception is the random eviction of a full table, which is checked by counting the surviving translations.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int ASID_W  = 8;
  localparam int ENTRIES = 16;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PFN_W   = PA_W - OFF_W;
  localparam int IDX_W   = $clog2(ENTRIES);
  // Galois feedback mask for a maximal-length 4-bit sequence (x^4 + x^3 + 1)
  localparam logic [IDX_W-1:0] LFSR_MASK = IDX_W'(4'hC);

  typedef struct packed {
    logic usr;
    logic wr;
    logic rd;
  } perm_t;

  typedef struct packed {
    logic              vld;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    perm_t             perm;
  } slot_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
(
  input  slot_t [ENTRIES-1:0] slots,
  input  logic [VPN_W-1:0]    look_vpn,
  input  logic [ASID_W-1:0]   look_asid,
  output logic                any_hit,
  output logic [IDX_W-1:0]    sel_idx,
  output slot_t               sel_slot
);
  logic [ENTRIES-1:0] raw;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign raw[g] = slots[g].vld && (slots[g].vpn == look_vpn) &&
                    (slots[g].asid == look_asid);
  end

  // scan from the top so the lowest matching index wins
  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (raw[i]) sel_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |raw;
  assign sel_slot = slots[sel_idx];
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld_vec,
  output logic               has_free,
  output logic [IDX_W-1:0]   vic_idx
);
  logic [IDX_W-1:0] lfsr_q;
  logic [IDX_W-1:0] free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= IDX_W'(1);
    else        lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? LFSR_MASK : '0);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign has_free = ~&vld_vec;
  assign vic_idx  = has_free ? free_idx : lfsr_q;

  // R8: the random selector never sits in the all-zero lock-up state
  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              fill_usr,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  slot_t [ENTRIES-1:0] slots_q;
  logic  [ENTRIES-1:0] vld_vec;
  logic                flush_any, fill_go, accept;
  logic                has_free;
  logic [IDX_W-1:0]    vic_idx;
  logic                any_hit;
  logic [IDX_W-1:0]    sel_idx;
  slot_t               sel_slot;
  logic                allowed;
  slot_t               new_slot;

  assign flush_any  = flush_all | flush_asid_en;
  assign fill_ready = !flush_any;
  assign fill_go    = fill_valid && fill_ready;
  assign req_ready  = !flush_any && !fill_valid;
  assign accept     = req_valid && req_ready;

  assign new_slot = '{vld: 1'b1, asid: fill_asid, vpn: fill_vpn, pfn: fill_pfn,
                      perm: '{usr: fill_usr, wr: fill_wr, rd: fill_rd}};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots_q[g] <= '0;
      else if (flush_all)
        slots_q[g].vld <= 1'b0;
      else if (flush_asid_en && slots_q[g].asid == flush_asid)
        slots_q[g].vld <= 1'b0;
      else if (fill_go && vic_idx == IDX_W'(g))
        slots_q[g] <= new_slot;
    end
    assign vld_vec[g] = slots_q[g].vld;
  end

  xlat_victim u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_vec  (vld_vec),
    .has_free (has_free),
    .vic_idx  (vic_idx)
  );

  xlat_match u_match (
    .slots     (slots_q),
    .look_vpn  (req_vaddr[VA_W-1:OFF_W]),
    .look_asid (req_asid),
    .any_hit   (any_hit),
    .sel_idx   (sel_idx),
    .sel_slot  (sel_slot)
  );

  assign allowed = (req_write ? sel_slot.perm.wr : sel_slot.perm.rd) &&
                   (!req_user || sel_slot.perm.usr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= accept && any_hit && allowed;
      rsp_fault <= accept && any_hit && !allowed;
      rsp_miss  <= accept && !any_hit;
      rsp_paddr <= (accept && any_hit && allowed) ?
                   {sel_slot.pfn, req_vaddr[OFF_W-1:0]} : '0;
    end
  end

  // R6: one outcome per response, none without one
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
  // R2: the page offset passes through untouched
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_hit ||
      rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
  // R7: a fill with room adds exactly one valid slot
  a_r7_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && has_free) |=> $countones(vld_vec) == $past($countones(vld_vec)) + 1);
  // R8: a fill into a full table leaves it full
  a_r8_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !has_free) |=> &vld_vec);
  // R9: global flush empties the table
  a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> vld_vec == '0);
  // R12: fill and flush hold lookups off
  a_r12_lookup_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || flush_any) |-> !req_ready);
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_ready;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 0, fill_rd = 0, fill_wr = 0, fill_usr = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [7:0]  fill_asid = '0, flush_asid = '0;
  logic        flush_all = 0, flush_asid_en = 0;

  int total = 0, bad = 0, cyc = 0;
  bit fin = 0;

  // slot model
  bit        m_vld [16];
  bit [7:0]  m_asid[16];
  bit [19:0] m_vpn [16];
  bit [19:0] m_pfn [16];
  bit [2:0]  m_perm[16]; // {usr, wr, rd}

  always #2 clk = ~clk;

  xlat_cache u_xlat_cache (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !fin) begin
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void mdl(input bit [19:0] vpn, input bit [7:0] asid, input bit wr,
                              input bit us, output int oc, output bit [19:0] pfn);
    oc = 0; pfn = '0;
    for (int i = 0; i < 16; i++) begin
      if (m_vld[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
        bit ok;
        ok = (wr ? m_perm[i][1] : m_perm[i][0]) && (!us || m_perm[i][2]);
        oc = ok ? 1 : 2;
        pfn = m_pfn[i];
        return;
      end
    end
  endfunction

  function automatic int model_count();
    int n = 0;
    for (int i = 0; i < 16; i++) if (m_vld[i]) n++;
    return n;
  endfunction

  task automatic lookup(input bit [31:0] va, input bit [7:0] asid, input bit wr,
                        input bit us, output int oc, output bit [31:0] pa);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_asid = asid; req_write = wr; req_user = us;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    oc = rsp_hit ? 1 : rsp_fault ? 2 : rsp_miss ? 0 : -1;
    pa = rsp_paddr;
    chk(rsp_valid && $countones({rsp_hit, rsp_miss, rsp_fault}) == 1, "R6 single outcome",
        {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 4'b1000);
    @(negedge clk);
    chk(!rsp_valid, "R6 response lasts one cycle", rsp_valid, 0);
  endtask

  task automatic look_chk(input bit [31:0] va, input bit [7:0] asid, input bit wr,
                          input bit us, input string tag);
    int oc, eoc; bit [31:0] pa, epa; bit [19:0] pfn;
    mdl(va[31:12], asid, wr, us, eoc, pfn);
    epa = (eoc == 1) ? {pfn, va[11:0]} : 32'h0;
    lookup(va, asid, wr, us, oc, pa);
    chk(oc == eoc, {tag, " outcome"}, oc, eoc);
    chk(pa == epa, {tag, " paddr"}, pa, epa);
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [7:0] asid, input bit [19:0] pfn,
                      input bit [2:0] perm);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
    {fill_usr, fill_wr, fill_rd} = perm;
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      if (!m_vld[i]) begin
        m_vld[i] = 1; m_vpn[i] = vpn; m_asid[i] = asid; m_pfn[i] = pfn; m_perm[i] = perm;
        break;
      end
    end
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic flush_everything();
    @(negedge clk);
    flush_all = 1;
    @(posedge clk);
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    @(negedge clk);
    flush_all = 0;
  endtask

  task automatic flush_space(input bit [7:0] asid);
    @(negedge clk);
    flush_asid_en = 1; flush_asid = asid;
    @(posedge clk);
    for (int i = 0; i < 16; i++) if (m_asid[i] == asid) m_vld[i] = 0;
    @(negedge clk);
    flush_asid_en = 0;
  endtask

  initial begin
    int oc; bit [31:0] pa; int survivors;
    void'($urandom(32'd9137));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(!rsp_valid, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(req_ready && fill_ready, "R1 readies after reset", {req_ready, fill_ready}, 2'b11);
    look_chk(32'h1234_5678, 8'd1, 0, 0, "R1 first lookup misses");

    // R2/R7 basic fill then hit
    fill(20'h12345, 8'd1, 20'hABCDE, 3'b111);
    lookup(32'h1234_5678, 8'd1, 0, 1, oc, pa);
    chk(oc == 1, "R2 hit outcome", oc, 1);
    chk(pa == 32'hABCD_E678, "R2 hit paddr", pa, 32'hABCD_E678);
    look_chk(32'h1234_5FFF, 8'd1, 1, 0, "R7 fill seen next lookup");

    // R3 other address space
    look_chk(32'h1234_5678, 8'd2, 0, 0, "R3 foreign asid misses");
    // R5 unknown page
    look_chk(32'h9999_9000, 8'd1, 0, 0, "R5 unknown page misses");

    // R4 permissions: readable only, kernel only
    fill(20'h00010, 8'd1, 20'h55555, 3'b001);
    look_chk(32'h0001_0004, 8'd1, 1, 0, "R4 write denied");
    look_chk(32'h0001_0004, 8'd1, 0, 1, "R4 user denied");
    look_chk(32'h0001_0004, 8'd1, 0, 0, "R4 kernel read allowed");
    fill(20'h00020, 8'd1, 20'h66666, 3'b110);
    look_chk(32'h0002_0000, 8'd1, 0, 1, "R4 read denied without rd");
    look_chk(32'h0002_0000, 8'd1, 1, 1, "R4 user write allowed");

    // R11 duplicate: lowest slot wins
    fill(20'h12345, 8'd1, 20'h11111, 3'b111);
    lookup(32'h1234_5010, 8'd1, 0, 0, oc, pa);
    chk(pa == 32'hABCD_E010, "R11 lowest slot wins", pa, 32'hABCD_E010);

    // R10 flush one address space
    fill(20'h00007, 8'd9, 20'h77777, 3'b011);
    flush_space(8'd1);
    look_chk(32'h1234_5000, 8'd1, 0, 0, "R10 flushed asid misses");
    look_chk(32'h0000_7123, 8'd9, 0, 0, "R10 other asid kept");

    // R12 priorities and back-pressure
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h0BEEF; fill_asid = 8'd9; fill_pfn = 20'h22222;
    {fill_usr, fill_wr, fill_rd} = 3'b111;
    #1;
    chk(!req_ready && fill_ready, "R12 fill holds lookup", {req_ready, fill_ready}, 2'b01);
    flush_all = 1;
    #1;
    chk(!req_ready && !fill_ready, "R12 flush holds fill", {req_ready, fill_ready}, 2'b00);
    @(posedge clk);
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    @(negedge clk);
    fill_valid = 0; flush_all = 0;
    #1;
    chk(req_ready && fill_ready, "R12 readies return", {req_ready, fill_ready}, 2'b11);
    look_chk(32'h0BEE_F000, 8'd9, 0, 0, "R12 fill during flush dropped");
    // R9 global flush
    look_chk(32'h0000_7123, 8'd9, 0, 0, "R9 all slots flushed");

    // R8 full-table eviction
    for (int i = 0; i < 16; i++) fill(20'h40000 + 20'(i), 8'd5, 20'h30000 + 20'(i), 3'b111);
    fill(20'h4FFFF, 8'd5, 20'h3FFFF, 3'b111);
    survivors = 0;
    for (int i = 0; i < 16; i++) begin
      lookup({20'h40000 + 20'(i), 12'h0}, 8'd5, 0, 0, oc, pa);
      if (oc == 1) survivors++;
      if (i == 0) chk(oc == 1, "R8 slot 0 never evicted", oc, 1);
    end
    chk(survivors == 15, "R8 exactly one evicted", survivors, 15);
    lookup(32'h4FFF_F000, 8'd5, 0, 0, oc, pa);
    chk(oc == 1 && pa == 32'h3FFF_F000, "R8 new entry installed", pa, 32'h3FFF_F000);
    flush_everything();

    // constrained random against the model (table kept below full)
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      bit [19:0] vpn = 20'($urandom_range(0, 7));
      bit [7:0]  asid = 8'($urandom_range(1, 3));
      if (op <= 5) begin
        look_chk({vpn, 12'($urandom)}, asid, 1'($urandom), 1'($urandom), "R2 random lookup");
      end else if (op <= 8) begin
        if (model_count() >= 14) flush_everything();
        else fill(vpn, asid, 20'($urandom), 3'($urandom));
      end else begin
        flush_space(asid);
      end
    end

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule